// File: doc/BRIEF.md
# Multi-Pattern Symbol Sequence Counter

The block takes an 18-bit word in one parallel load and reads it as nine 2-bit symbols, one symbol on each clock where the enable is high. A single shared state machine watches the symbol stream for three target triplets. The triplets are B-D-A, B-A-A and B-A-D, over the alphabet A, B, C and D. Every hit produces a one-cycle pulse and advances a saturating tally. Once the ninth symbol has been consumed, a done flag rises and stays high.

A start strobe loads the word, clears the tally and the flag, and restarts the scan. A start that arrives during a scan abandons that scan. Typical use: pulse start together with the word, hold the enable, wait for done, then read the tally.

Top module: `sym_pattern_counter`

## Requirements
- R1: After a synchronous reset, `hit_o` is 0, `count_o` is 0 and `done_o` is 0.
- R2: Symbols are coded A=00, B=01, C=10 and D=11. Bits [17:16] are consumed first, then [15:14], and so on down to [1:0]. Exactly one symbol is consumed on each cycle where `en_i` is high.
- R3: `hit_o` is high for exactly one cycle, in the cycle after the edge that consumes a symbol completing B-D-A, B-A-A or B-A-D.
- R4: `count_o` rises by one on the same edge that raises `hit_o`, and it never changes otherwise, except when it is cleared.
- R5: After a hit the search starts over, so two hits never share symbols. A B received in the middle of a partial pattern is taken as a new leading B, so B-B-D-A counts as one hit.
- R6: A C, or a second D after B-D, discards the partial pattern. For example, B-D-D produces no hit and B-C-A produces no hit.
- R7: A cycle with `en_i` low consumes no symbol and produces no hit.
- R8: `done_o` rises in the cycle after the ninth symbol is consumed and stays high until the next start. While `done_o` is high, further enables change neither `hit_o` nor `count_o`.
- R9: `start_i` loads `data_i`, clears `count_o`, `hit_o` and `done_o`, and resets the pattern search. This holds even in the middle of a scan, and `start_i` wins over `en_i` in the same cycle.
- R10: `count_o` saturates at its maximum value (2^CNT_W-1) instead of wrapping.
- R11: Enables that arrive after reset but before the first start are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Load strobe; begins a new scan |
| data_i | input | 18 | Word of nine 2-bit symbols, sampled on start |
| en_i | input | 1 | Consume one symbol this cycle |
| hit_o | output | 1 | One-cycle pulse per recognised triplet |
| count_o | output | CNT_W (4) | Saturating number of triplets found since start |
| done_o | output | 1 | All nine symbols consumed |

## Verification
Several input words are used, and each one separates a different behaviour.

- A word that holds all three triplets back to back gives three hits in order. Read in the reverse symbol order, the same word would give only two, so it also pins down the symbol order.
- A word built from near misses (B-D-D, B-C-A, and a repeated B before D-A) separates correct abandonment and restart from over-eager matching.
- Enable gaps, enables after done, and enables before any load show whether stalls and idle periods really consume nothing.
- A start in the middle of a scan, together with a narrow-counter instance, exposes stale history and counter wrap.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [1:0] {
        SYM_A = 2'b00,
        SYM_B = 2'b01,
        SYM_C = 2'b10,
        SYM_D = 2'b11
    } sym_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_GOT_B = 2'd1,
        ST_B_A   = 2'd2,
        ST_B_D   = 2'd3
    } srch_e;

    typedef struct packed {
        srch_e nxt;
        logic  match;
    } srch_step_t;

    // One transition of the shared triplet recogniser.
    function automatic srch_step_t srch_step(input srch_e cur, input sym_e sym);
        srch_step_t r;
        r.match = 1'b0;
        r.nxt   = ST_IDLE;
        case (cur)
            ST_IDLE: begin
                r.nxt = (sym == SYM_B) ? ST_GOT_B : ST_IDLE;
            end
            ST_GOT_B: begin
                case (sym)
                    SYM_A:   r.nxt = ST_B_A;
                    SYM_D:   r.nxt = ST_B_D;
                    SYM_B:   r.nxt = ST_GOT_B;
                    default: r.nxt = ST_IDLE;
                endcase
            end
            ST_B_A: begin
                case (sym)
                    SYM_A, SYM_D: begin
                        r.match = 1'b1;
                        r.nxt   = ST_IDLE;
                    end
                    SYM_B:   r.nxt = ST_GOT_B;
                    default: r.nxt = ST_IDLE;
                endcase
            end
            ST_B_D: begin
                case (sym)
                    SYM_A: begin
                        r.match = 1'b1;
                        r.nxt   = ST_IDLE;
                    end
                    SYM_B:   r.nxt = ST_GOT_B;
                    default: r.nxt = ST_IDLE;
                endcase
            end
            default: r.nxt = ST_IDLE;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spc_symbol_feed.sv
module spc_symbol_feed #(
    parameter int SYM_W   = 2,
    parameter int NUM_SYM = 9
) (
    input  logic                     clk_i,
    input  logic                     rst_i,
    input  logic                     start_i,
    input  logic [SYM_W*NUM_SYM-1:0] data_i,
    input  logic                     en_i,
    output logic [SYM_W-1:0]         sym_o,
    output logic                     sym_vld_o,
    output logic                     done_o
);
    localparam int WORD_W = SYM_W * NUM_SYM;
    localparam int IDX_W  = (NUM_SYM > 1) ? $clog2(NUM_SYM) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_SYM - 1);

    typedef struct packed {
        logic [WORD_W-1:0] shreg;
        logic [IDX_W-1:0]  idx;
        logic              active;
        logic              done;
    } feed_t;

    feed_t feed_d, feed_q;
    logic  consume;

    assign consume   = feed_q.active && en_i && !start_i;
    assign sym_o     = feed_q.shreg[WORD_W-1 -: SYM_W];
    assign sym_vld_o = consume;
    assign done_o    = feed_q.done;

    always_comb begin
        feed_d = feed_q;
        if (start_i) begin
            feed_d.shreg  = data_i;
            feed_d.idx    = '0;
            feed_d.active = 1'b1;
            feed_d.done   = 1'b0;
        end else if (consume) begin
            feed_d.shreg = feed_q.shreg << SYM_W;
            if (feed_q.idx == LAST_IDX) begin
                feed_d.idx    = '0;
                feed_d.active = 1'b0;
                feed_d.done   = 1'b1;
            end else begin
                feed_d.idx = feed_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            feed_q <= '0;
        end else begin
            feed_q <= feed_d;
        end
    end

endmodule

// File: rtl/spc_pattern_fsm.sv
module spc_pattern_fsm
    import spc_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_i,
    input  logic       start_i,
    input  logic [1:0] sym_i,
    input  logic       sym_vld_i,
    output logic       match_o,
    output logic       hit_o
);
    typedef struct packed {
        srch_e st;
        logic  hit;
    } fsm_t;

    fsm_t       fsm_d, fsm_q;
    srch_step_t step;

    assign step    = srch_step(fsm_q.st, sym_e'(sym_i));
    assign match_o = sym_vld_i && !start_i && step.match;
    assign hit_o   = fsm_q.hit;

    always_comb begin
        fsm_d     = fsm_q;
        fsm_d.hit = 1'b0;
        if (start_i) begin
            fsm_d.st = ST_IDLE;
        end else if (sym_vld_i) begin
            fsm_d.st  = step.nxt;
            fsm_d.hit = step.match;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fsm_q <= '{st: ST_IDLE, hit: 1'b0};
        end else begin
            fsm_q <= fsm_d;
        end
    end

endmodule

// File: rtl/spc_sat_counter.sv
module spc_sat_counter #(
    parameter int CNT_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_t;

    cnt_t cnt_d, cnt_q;

    assign cnt_o = cnt_q.cnt;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d.cnt = '0;
        end else if (inc_i && (cnt_q.cnt != CNT_MAX)) begin
            cnt_d.cnt = cnt_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/sym_pattern_counter.sv
module sym_pattern_counter #(
    parameter int SYM_W   = 2,
    parameter int NUM_SYM = 9,
    parameter int CNT_W   = 4,
    localparam int WORD_W = SYM_W * NUM_SYM
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              start_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              en_i,
    output logic              hit_o,
    output logic [CNT_W-1:0]  count_o,
    output logic              done_o
);
    logic [SYM_W-1:0] cur_sym;
    logic             cur_vld;
    logic             match;

    spc_symbol_feed #(
        .SYM_W  (SYM_W),
        .NUM_SYM(NUM_SYM)
    ) feed_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (start_i),
        .data_i   (data_i),
        .en_i     (en_i),
        .sym_o    (cur_sym),
        .sym_vld_o(cur_vld),
        .done_o   (done_o)
    );

    spc_pattern_fsm fsm_i (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .start_i  (start_i),
        .sym_i    (cur_sym),
        .sym_vld_i(cur_vld),
        .match_o  (match),
        .hit_o    (hit_o)
    );

    spc_sat_counter #(
        .CNT_W(CNT_W)
    ) cnt_i (
        .clk_i(clk_i),
        .rst_i(rst_i),
        .clr_i(start_i),
        .inc_i(match),
        .cnt_o(count_o)
    );

endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
    parameter int CNT_W = 4
) (
    input logic             clk_i,
    input logic             rst_i,
    input logic             start_i,
    input logic             en_i,
    input logic             hit_o,
    input logic [CNT_W-1:0] count_o,
    input logic             done_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    AST_HIT_SINGLE: assert property (@(posedge clk_i) disable iff (rst_i)
        hit_o |=> !hit_o); // R3

    AST_COUNT_STEP: assert property (@(posedge clk_i) disable iff (rst_i)
        !start_i |=> ((count_o == $past(count_o)) ||
                      (hit_o && (count_o == $past(count_o) + 1'b1)))); // R4

    AST_NO_CONSUME_STALL: assert property (@(posedge clk_i) disable iff (rst_i)
        (!en_i && !start_i) |=> !hit_o); // R7

    AST_DONE_STICKY: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !start_i) |=> done_o); // R8

    AST_DONE_FROZEN: assert property (@(posedge clk_i) disable iff (rst_i)
        (done_o && !start_i) |=> (!hit_o && $stable(count_o))); // R8

    AST_START_CLEARS: assert property (@(posedge clk_i) disable iff (rst_i)
        start_i |=> (count_o == '0 && !hit_o && !done_o)); // R9

    AST_NO_WRAP: assert property (@(posedge clk_i) disable iff (rst_i)
        (count_o == CNT_MAX && !start_i) |=> (count_o == CNT_MAX)); // R10

endmodule

bind sym_pattern_counter spc_checker #(.CNT_W(CNT_W)) chk_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .start_i(start_i),
    .en_i   (en_i),
    .hit_o  (hit_o),
    .count_o(count_o),
    .done_o (done_o)
);

// File: tb/sym_pattern_counter_tb_top.sv
`timescale 1ns/1ps
module sym_pattern_counter_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start;
    logic [17:0] data;
    logic        en;
    logic        hit;
    logic [3:0]  count;
    logic        done;
    logic        hit_s;
    logic [0:0]  count_s;
    logic        done_s;

    int checks = 0;
    int errors = 0;

    // Bench model state
    int       m_k;
    int       m_raw;
    logic     m_active;
    logic     m_done;
    logic     m_hit;
    logic [17:0] m_word;
    logic [5:0]  m_hist;

    always #2 clk = ~clk;

    sym_pattern_counter dut_i (
        .clk_i(clk), .rst_i(rst), .start_i(start), .data_i(data), .en_i(en),
        .hit_o(hit), .count_o(count), .done_o(done)
    );

    sym_pattern_counter #(.CNT_W(1)) dut_sat_i (
        .clk_i(clk), .rst_i(rst), .start_i(start), .data_i(data), .en_i(en),
        .hit_o(hit_s), .count_o(count_s), .done_o(done_s)
    );

    function automatic logic is_target(input logic [5:0] w);
        return (w == 6'b01_11_00) || (w == 6'b01_00_00) || (w == 6'b01_00_11);
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic model_edge(input logic s, input logic [17:0] w, input logic e);
        m_hit = 1'b0;
        if (s) begin
            m_word = w; m_k = 0; m_raw = 0; m_hist = '0;
            m_active = 1'b1; m_done = 1'b0;
        end else if (e && m_active) begin
            m_hist = {m_hist[3:0], m_word[17-2*m_k -: 2]};
            m_k++;
            if (m_k >= 3 && is_target(m_hist)) begin
                m_hit = 1'b1;
                m_raw++;
            end
            if (m_k == 9) begin
                m_active = 1'b0;
                m_done = 1'b1;
            end
        end
    endtask

    // Called just after a negedge: drive, cross a rising edge, check at the next negedge.
    task automatic step(input logic s, input logic [17:0] w, input logic e, input string tag);
        start = s; data = w; en = e;
        @(posedge clk);
        model_edge(s, w, e);
        @(negedge clk);
        check(tag, "hit_o", int'(hit), int'(m_hit));
        check(tag, "count_o", int'(count), (m_raw > 15) ? 15 : m_raw);
        check(tag, "done_o", int'(done), int'(m_done));
        check("R10", "narrow count_o", int'(count_s), (m_raw > 1) ? 1 : m_raw);
    endtask

    task automatic scan(input logic [17:0] w, input logic [31:0] en_pat, input int n, input string tag);
        step(1'b1, w, 1'b0, tag);
        for (int i = 0; i < n; i++) step(1'b0, w, en_pat[i], tag);
    endtask

    task automatic t_reset();
        rst = 1'b1; start = 1'b0; data = '0; en = 1'b0;
        m_k = 0; m_raw = 0; m_active = 1'b0; m_done = 1'b0; m_hit = 1'b0;
        m_word = '0; m_hist = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1", "hit_o", int'(hit), 0);
        check("R1", "count_o", int'(count), 0);
        check("R1", "done_o", int'(done), 0);
    endtask

    task automatic t_before_start();
        // R11: enables with no load yet
        for (int i = 0; i < 5; i++) step(1'b0, 18'b01_11_00_01_00_00_01_00_11, 1'b1, "R11");
    endtask

    task automatic t_all_three();
        // R2 R3 R4: B D A B A A B A D -> three hits, two if read backwards
        scan(18'b01_11_00_01_00_00_01_00_11, 32'hFFFF_FFFF, 10, "R3");
        check("R4", "final count_o", int'(count), 3);
        check("R2", "done after nine", int'(done), 1);
    endtask

    task automatic t_near_miss();
        // R5 R6: C B B D A D D B D -> one hit
        scan(18'b10_01_01_11_00_11_11_01_11, 32'hFFFF_FFFF, 10, "R5");
        check("R5", "final count_o", int'(count), 1);
        // R6: B D D B C A B C A -> no hit
        scan(18'b01_11_11_01_10_00_01_10_00, 32'hFFFF_FFFF, 10, "R6");
        check("R6", "final count_o", int'(count), 0);
    endtask

    task automatic t_stall();
        // R7: gaps in enable; same word as the three-hit case
        scan(18'b01_11_00_01_00_00_01_00_11, 32'b1010_0110_1100_1011_0101, 20, "R7");
        check("R7", "final count_o", int'(count), 3);
    endtask

    task automatic t_done_hold();
        // R8: extra enables after the ninth symbol
        scan(18'b01_00_00_01_00_11_00_00_00, 32'hFFFF_FFFF, 15, "R8");
        check("R8", "final count_o", int'(count), 2);
        check("R8", "done_o held", int'(done), 1);
    endtask

    task automatic t_restart();
        // R9: abort after four symbols, reload a different word
        scan(18'b01_11_00_01_00_00_01_00_11, 32'hF, 4, "R9");
        check("R9", "partial count_o", int'(count), 1);
        step(1'b1, 18'b01_00_00_00_00_00_00_00_00, 1'b1, "R9");
        check("R9", "count_o cleared", int'(count), 0);
        for (int i = 0; i < 10; i++) step(1'b0, 18'b01_00_00_00_00_00_00_00_00, 1'b1, "R9");
        check("R9", "count_o after reload", int'(count), 1);
    endtask

    task automatic t_flat_words();
        scan(18'h00000, 32'hFFFF_FFFF, 10, "R2");
        scan(18'b01_01_01_01_01_01_01_01_01, 32'hFFFF_FFFF, 10, "R2");
        check("R2", "all-B count_o", int'(count), 0);
    endtask

    initial begin : watchdog
        #400000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_before_start();
        t_all_three();
        t_near_miss();
        t_stall();
        t_done_hold();
        t_restart();
        t_flat_words();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule